// File: doc/BRIEF.md
# Sum-Difference Digit Pair Codec

This block carries a pair of decimal digits across a 14-bit parallel link. The digits are not sent as raw characters. Each one arrives as a 7-bit ASCII character ('0' to '9'). The transmit half turns the pair into their sum and their signed difference, and it drives both fields onto the link in the same cycle. The receive half sees only those two fields. It rebuilds the two digits arithmetically and presents them again as ASCII characters.

A producer presents both characters together with a one-cycle valid strobe. One cycle later the link word and its valid flag appear. One cycle after that the recovered character pair and its valid flag appear. A new pair may be presented on every cycle. When no strobe is present, every output register keeps its last value. Only digit characters are legal input. Capturing keys and showing results are handled elsewhere.

Top module: `digit_pair_codec`

## Requirements
- R1: While `rst_n` is low, at each clock edge `link_word`, `link_valid`, `pair_valid`, `pair_char_a` and `pair_char_b` are all cleared to zero.
- R2: One cycle after a clock edge with `src_valid` high, `link_word[13:7]` holds the unsigned sum of the two digit values. Each digit value is its ASCII code minus 0x30, so the sum ranges from 0 to 18.
- R3: In the same cycle, `link_word[6:0]` holds the value of the first digit (`src_char_a`) minus the value of the second (`src_char_b`), as 7-bit two's complement.
- R4: `link_valid` is high exactly in the cycle after each edge at which `src_valid` was high, and low otherwise.
- R5: `pair_valid` is high exactly one cycle after `link_valid`. In that cycle `pair_char_a` and `pair_char_b` equal the ASCII characters that were presented two cycles earlier.
- R6: While `src_valid` is low, the characters on `src_char_a`/`src_char_b` are ignored: `link_word` keeps its value. While `link_valid` is low, `pair_char_a`/`pair_char_b` keep their values.
- R7: Pairs presented on consecutive cycles are each encoded and recovered independently, one pair per cycle, covering all 100 digit combinations.
- R8: The end cases are exact. '9','0' gives sum 9 with difference 0x09. '0','9' gives sum 9 with difference 0x77 (-9). '9','9' gives sum 18 with difference 0. All three recover to the original characters.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| src_valid | input | 1 | Strobe: the character pair is valid this cycle |
| src_char_a | input | 7 | ASCII code of the first digit |
| src_char_b | input | 7 | ASCII code of the second digit |
| link_word | output | 14 | Link word: sum in [13:7], difference in [6:0] |
| link_valid | output | 1 | Link word carries a new pair |
| pair_char_a | output | 7 | Recovered ASCII code of the first digit |
| pair_char_b | output | 7 | Recovered ASCII code of the second digit |
| pair_valid | output | 1 | Recovered pair is new this cycle |

## Verification
There are two ways an internal fault can show. A wrong sum or difference register shows on `link_word` one cycle after the strobe. A decoding fault shows on the recovered characters one cycle later. Because (a+b)+(a-b) is always even, the two link fields must agree in bit 0, so a corrupted field is often caught on the very word it damages. A valid flag that is stuck or delayed, or a hold register that takes in idle-cycle data, changes the ports at the next edge and is compared against the reference model on every clock.

// File: rtl/codec_pkg.sv
// Package: shared constants and the link-word layout for the digit pair codec.
// Assumes characters are ASCII digits, so values fit a field of the character width.
package codec_pkg;
    localparam int              CODEC_CHAR_W = 7;
    localparam logic [6:0]      CODEC_ZERO   = 7'h30;

    // Layout of the link word: sum in the upper field, difference in the lower.
    typedef struct packed {
        logic [CODEC_CHAR_W-1:0] sum_f;
        logic [CODEC_CHAR_W-1:0] diff_f;
    } link_word_t;
endpackage

// File: rtl/pair_encoder.sv
// Module: pair_encoder
// Turns two ASCII digit characters into a registered link word {sum, a-b}.
// Assumes both characters lie in '0'..'9'; the difference is two's complement.
// Holds the word when no strobe is present.
module pair_encoder #(
    parameter int                CHAR_W    = codec_pkg::CODEC_CHAR_W,
    parameter logic [CHAR_W-1:0] ZERO_CHAR = codec_pkg::CODEC_ZERO
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  src_valid,
    input  logic [CHAR_W-1:0]     src_char_a,
    input  logic [CHAR_W-1:0]     src_char_b,
    output logic [2*CHAR_W-1:0]   link_word,
    output logic                  link_valid
);
    localparam int LANES = 2;

    logic [LANES-1:0][CHAR_W-1:0] chars;
    logic [LANES-1:0][CHAR_W-1:0] vals;
    logic [CHAR_W-1:0]            sum_v;
    logic [CHAR_W-1:0]            diff_v;

    assign chars[0] = src_char_a;
    assign chars[1] = src_char_b;

    // Per-lane ASCII to digit value conversion.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign vals[g] = chars[g] - ZERO_CHAR;
    end

    // Sum and signed difference of the two digit values.
    always_comb begin
        sum_v  = vals[0] + vals[1];
        diff_v = vals[0] - vals[1];
    end

    // Register the link word on a strobe; the valid flag follows the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_word  <= '0;
            link_valid <= 1'b0;
        end else begin
            link_valid <= src_valid;
            if (src_valid) begin
                link_word <= {sum_v, diff_v};
            end
        end
    end
endmodule

// File: rtl/pair_decoder.sv
// Module: pair_decoder
// Rebuilds two digits from a link word {sum, a-b} and re-emits them as ASCII.
// first = (sum + diff) / 2 and second = (sum - diff) / 2, using intermediates
// one bit wider than a field. Assumes the word came from a digit pair.
module pair_decoder #(
    parameter int                CHAR_W    = codec_pkg::CODEC_CHAR_W,
    parameter logic [CHAR_W-1:0] ZERO_CHAR = codec_pkg::CODEC_ZERO
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2*CHAR_W-1:0]   link_word,
    input  logic                  link_valid,
    output logic [CHAR_W-1:0]     pair_char_a,
    output logic [CHAR_W-1:0]     pair_char_b,
    output logic                  pair_valid
);
    localparam int LANES = 2;
    localparam int EXT_W = CHAR_W + 1;

    logic [CHAR_W-1:0]            sum_f;
    logic [CHAR_W-1:0]            diff_f;
    logic [EXT_W-1:0]             sum_x;
    logic [EXT_W-1:0]             diff_x;
    logic [LANES-1:0][CHAR_W-1:0] digs;
    logic [LANES-1:0][CHAR_W-1:0] chrs;

    assign {sum_f, diff_f} = link_word;

    // Widen: the sum is unsigned, the difference is sign-extended.
    always_comb begin
        sum_x  = {1'b0, sum_f};
        diff_x = {diff_f[CHAR_W-1], diff_f};
    end

    // Invert the transform: halve the sum and the difference of the two fields.
    always_comb begin
        digs[0] = CHAR_W'((sum_x + diff_x) >> 1);
        digs[1] = CHAR_W'((sum_x - diff_x) >> 1);
    end

    // Per-lane digit value to ASCII conversion.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign chrs[g] = digs[g] + ZERO_CHAR;
    end

    // Register the recovered pair when a link word arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pair_char_a <= '0;
            pair_char_b <= '0;
            pair_valid  <= 1'b0;
        end else begin
            pair_valid <= link_valid;
            if (link_valid) begin
                pair_char_a <= chrs[0];
                pair_char_b <= chrs[1];
            end
        end
    end
endmodule

// File: rtl/digit_pair_codec.sv
// Module: digit_pair_codec
// Encoder and decoder joined by the 14-bit link. The link word is brought out
// so that the encoded form can be observed. Latency is one cycle to the link
// and one more cycle to the recovered characters.
module digit_pair_codec #(
    parameter int                CHAR_W    = codec_pkg::CODEC_CHAR_W,
    parameter logic [CHAR_W-1:0] ZERO_CHAR = codec_pkg::CODEC_ZERO
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  src_valid,
    input  logic [CHAR_W-1:0]     src_char_a,
    input  logic [CHAR_W-1:0]     src_char_b,
    output logic [2*CHAR_W-1:0]   link_word,
    output logic                  link_valid,
    output logic [CHAR_W-1:0]     pair_char_a,
    output logic [CHAR_W-1:0]     pair_char_b,
    output logic                  pair_valid
);
    pair_encoder #(.CHAR_W(CHAR_W), .ZERO_CHAR(ZERO_CHAR)) enc_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_valid  (src_valid),
        .src_char_a (src_char_a),
        .src_char_b (src_char_b),
        .link_word  (link_word),
        .link_valid (link_valid)
    );

    pair_decoder #(.CHAR_W(CHAR_W), .ZERO_CHAR(ZERO_CHAR)) dec_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .link_word   (link_word),
        .link_valid  (link_valid),
        .pair_char_a (pair_char_a),
        .pair_char_b (pair_char_b),
        .pair_valid  (pair_valid)
    );
endmodule

// File: rtl/codec_checker.sv
// Module: codec_checker
// Protocol and data properties of digit_pair_codec, attached by bind.
// Assumes only digit characters are strobed in.
module codec_checker #(
    parameter int                CHAR_W    = 7,
    parameter logic [CHAR_W-1:0] ZERO_CHAR = 7'h30
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  src_valid,
    input logic [CHAR_W-1:0]     src_char_a,
    input logic [CHAR_W-1:0]     src_char_b,
    input logic [2*CHAR_W-1:0]   link_word,
    input logic                  link_valid,
    input logic [CHAR_W-1:0]     pair_char_a,
    input logic [CHAR_W-1:0]     pair_char_b,
    input logic                  pair_valid
);
    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> !link_valid && !pair_valid && link_word == '0); // R1
    AST_SUM_FIELD: assert property (@(posedge clk) disable iff (!rst_n) src_valid |=> link_word[2*CHAR_W-1:CHAR_W] == ($past(src_char_a) - ZERO_CHAR) + ($past(src_char_b) - ZERO_CHAR)); // R2
    AST_PARITY_MATCH: assert property (@(posedge clk) disable iff (!rst_n) link_valid |-> link_word[CHAR_W] == link_word[0]); // R3
    AST_LINK_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) src_valid |=> link_valid); // R4
    AST_LINK_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !src_valid |=> !link_valid); // R4
    AST_PAIR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) link_valid |=> pair_valid); // R5
    AST_ROUND_TRIP: assert property (@(posedge clk) disable iff (!rst_n) link_valid |=> pair_char_a == $past(src_char_a, 2) && pair_char_b == $past(src_char_b, 2)); // R5
    AST_HOLD_LINK: assert property (@(posedge clk) disable iff (!rst_n) !src_valid |=> $stable(link_word)); // R6
    AST_HOLD_PAIR: assert property (@(posedge clk) disable iff (!rst_n) !link_valid |=> $stable(pair_char_a) && $stable(pair_char_b)); // R6
endmodule

bind digit_pair_codec codec_checker #(.CHAR_W(CHAR_W), .ZERO_CHAR(ZERO_CHAR)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_valid   (src_valid),
    .src_char_a  (src_char_a),
    .src_char_b  (src_char_b),
    .link_word   (link_word),
    .link_valid  (link_valid),
    .pair_char_a (pair_char_a),
    .pair_char_b (pair_char_b),
    .pair_valid  (pair_valid)
);

// File: tb/digit_pair_codec_tb.sv
// Bench: digit_pair_codec_tb_top
// A behavioural cycle model, built from integer arithmetic, is compared with the ports on every clock.
`timescale 1ns/1ps
module digit_pair_codec_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        src_valid = 1'b0;
    logic [6:0]  src_char_a = 7'h30;
    logic [6:0]  src_char_b = 7'h30;
    logic [13:0] link_word;
    logic        link_valid;
    logic [6:0]  pair_char_a;
    logic [6:0]  pair_char_b;
    logic        pair_valid;

    int    total = 0;
    int    bad = 0;
    string tag = "R1";
    bit    done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    digit_pair_codec dut_i (
        .clk(clk), .rst_n(rst_n), .src_valid(src_valid),
        .src_char_a(src_char_a), .src_char_b(src_char_b),
        .link_word(link_word), .link_valid(link_valid),
        .pair_char_a(pair_char_a), .pair_char_b(pair_char_b), .pair_valid(pair_valid)
    );

    // Expected link word from integer digit arithmetic.
    function automatic logic [13:0] expect_word(input logic [6:0] a, input logic [6:0] b);
        int da = int'(a) - 48;
        int db = int'(b) - 48;
        int s  = da + db;
        int d  = (da - db + 128) % 128;
        return 14'(s * 128 + d);
    endfunction

    task automatic check(input string req, input int act, input int exp, input string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Reference model state.
    logic        m_lv, m_pv;
    logic [13:0] m_word;
    logic [6:0]  q_a, q_b, m_a, m_b;

    // Update the model at each edge from the inputs driven at the preceding negedge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_lv <= 1'b0; m_pv <= 1'b0; m_word <= '0;
            q_a <= '0; q_b <= '0; m_a <= '0; m_b <= '0;
        end else begin
            m_lv <= src_valid;
            m_pv <= m_lv;
            if (src_valid) begin
                m_word <= expect_word(src_char_a, src_char_b);
                q_a <= src_char_a;
                q_b <= src_char_b;
            end
            if (m_lv) begin
                m_a <= q_a;
                m_b <= q_b;
            end
        end
    end

    // Compare the ports with the model shortly after each edge.
    always @(posedge clk) begin
        #2;
        if (rst_n && !done) begin
            check("R4", int'(link_valid), int'(m_lv), "link_valid");
            if (m_lv) begin
                check("R2", int'(link_word[13:7]), int'(m_word[13:7]), "sum field");
                check("R3", int'(link_word[6:0]), int'(m_word[6:0]), "diff field");
            end else begin
                check("R6", int'(link_word), int'(m_word), "held link word");
            end
            check("R5", int'(pair_valid), int'(m_pv), "pair_valid");
            check(m_pv ? tag : "R6", int'(pair_char_a), int'(m_a), "pair_char_a");
            check(m_pv ? tag : "R6", int'(pair_char_b), int'(m_b), "pair_char_b");
        end
    end

    task automatic send(input logic [6:0] a, input logic [6:0] b);
        @(negedge clk);
        src_valid  = 1'b1;
        src_char_a = a;
        src_char_b = b;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            src_valid  = 1'b0;
            src_char_a = 7'(8'h41 + k);   // ignored characters
            src_char_b = 7'(8'h7a - k);
        end
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", int'(link_word), 0, "link_word in reset");
        check("R1", int'(link_valid), 0, "link_valid in reset");
        check("R1", int'(pair_valid), 0, "pair_valid in reset");
        check("R1", int'(pair_char_a), 0, "pair_char_a in reset");
        check("R1", int'(pair_char_b), 0, "pair_char_b in reset");
        rst_n = 1'b1;

        tag = "R5";
        send(7'h33, 7'h34);
        idle(3);

        tag = "R6";
        send(7'h31, 7'h38);
        idle(5);

        tag = "R7";
        for (int i = 0; i < 10; i++) begin
            for (int j = 0; j < 10; j++) begin
                send(7'(48 + i), 7'(48 + j));
            end
        end
        idle(3);

        tag = "R8";
        send(7'h39, 7'h30);
        idle(1);
        check("R8", int'(link_word), 14'h0489, "'9','0' link word");
        send(7'h30, 7'h39);
        idle(1);
        check("R8", int'(link_word), 14'h04F7, "'0','9' link word");
        send(7'h39, 7'h39);
        idle(1);
        check("R8", int'(link_word), 14'h0900, "'9','9' link word");
        idle(1);
        check("R8", int'(pair_char_a), 7'h39, "'9','9' recovered a");
        check("R8", int'(pair_char_b), 7'h39, "'9','9' recovered b");
        idle(2);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule